// File: doc/BRIEF.md
# DRAM Refresh Scheduler with DMA Yield

This block decides the clock edge on which an external DRAM refresh cycle is launched. A programmable interval timer marks a refresh as due. The block then raises a pending flag and waits until three things hold: the current memory cycle has ended, no external DMA master holds the bus, and no earlier refresh is still running. Only then does it emit a one-cycle start pulse to a separate bus sequencer.

The pending flag is a plain, always-driven output. An external DMA master can watch it and drop its bus request on its own so that the refresh can go ahead. The scheduler never takes the bus away from a DMA master. A companion output tells the external-cycle launcher to hold off new external accesses while a refresh is pending or running. Internal accesses are not affected by it.

After reset the block issues a fixed burst of dummy refreshes, flagged as dummy, that the sequencer runs with no bus or strobe activity. Each refresh, dummy or real, occupies the refresh slot for `RF_CYC` clock cycles.

Top module: `refresh_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `start_o`, `dummy_o`, `pend_o` and `ext_hold_o` are low.
- R2: After reset, exactly `NUM_DUMMY` (default 8) start pulses with `dummy_o` high are issued. The first comes on the first clock edge after `rst` falls, and the rest follow every `RF_CYC` cycles. They ignore `refresh_en_i`, `mem_busy_i` and `dma_req_i`, and they raise neither `pend_o` nor `ext_hold_o`.
- R3: While `refresh_en_i` is high, a refresh becomes due every `interval_i` cycles, and `pend_o` rises on the edge at which it becomes due. The first due comes on the first enabled edge after reset. After a disable, the first due comes `interval_i` edges after re-enable.
- R4: `pend_o` stays high until the edge that issues a real start (`start_o`=1, `dummy_o`=0). On that edge it falls unless a new due arrives on the same edge. A real start is only issued when `pend_o` has been high for at least one full cycle before it.
- R5: A real start is issued only on an edge where `mem_busy_i` and `dma_req_i` are both low, the dummy burst is over, and no refresh is occupying the slot. Real starts are therefore at least `RF_CYC` cycles apart.
- R6: Raising `dma_req_i` or `mem_busy_i` after a start has no effect on the refresh already started. That refresh still holds the slot for exactly `RF_CYC` cycles, so the next start can come `RF_CYC` cycles later.
- R7: Dues that arrive while a refresh is already pending merge into one outstanding refresh, which gives one real start.
- R8: When `refresh_en_i` is low at an edge, `pend_o` is low in the following cycle, and no real start is issued on that edge.
- R9: `ext_hold_o` is high whenever `pend_o` is high, and for the `RF_CYC-1` cycles after a real start. It is low otherwise, including during dummy refreshes.
- R10: `pend_o` is always driven to a known 0 or 1, including while `dma_req_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock; outputs change after its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| refresh_en_i | input | 1 | Refresh enable |
| interval_i | input | CNT_W | Cycles between refresh dues |
| mem_busy_i | input | 1 | A memory cycle is still in progress |
| dma_req_i | input | 1 | External master requests or holds the bus |
| start_o | output | 1 | One-cycle refresh start pulse to the sequencer |
| dummy_o | output | 1 | Qualifies `start_o` as a silent post-reset refresh |
| pend_o | output | 1 | Refresh pending, never high impedance |
| ext_hold_o | output | 1 | Defer new external cycles |

## Verification
A directed opening keeps `dma_req_i` high through the whole dummy burst and beyond. This separates dummies, which must ignore DMA, from real refreshes, which must wait, and shows `pend_o` holding for many cycles. A long random stretch mixes enable glitches, busy memory cycles, DMA bursts and intervals from 1 to 12 against a cycle model; this tells apart correct start edges from starts that are one cycle early, late or blocked. A disabled stretch confirms that pending stays low and no real start appears. A final run with an interval of 1 makes dues pile up, which exposes any failure to merge them into one outstanding refresh.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    KIND_NONE  = 2'd0,
    KIND_DUMMY = 2'd1,
    KIND_REAL  = 2'd2
  } rf_kind_e;
endpackage

// File: rtl/rs_due_timer.sv
module rs_due_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             due_o
);
  logic [CNT_W-1:0] tmr_q;

  // down-counter; expiry at one reloads from the programmed interval
  assign due_o = en_i && (tmr_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_q <= '0;
    end else if (!en_i || tmr_q <= CNT_W'(1)) begin
      tmr_q <= interval_i;
    end else begin
      tmr_q <= tmr_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/rs_dummy_seq.sv
module rs_dummy_seq #(
  parameter int NUM_DUMMY = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic take_i,
  output logic active_o
);
  localparam int DUM_W = $clog2(NUM_DUMMY + 1);

  logic [DUM_W-1:0] left_q;

  assign active_o = (left_q != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= DUM_W'(NUM_DUMMY);
    end else if (take_i && active_o) begin
      left_q <= left_q - DUM_W'(1);
    end
  end
endmodule

// File: rtl/rs_slot_track.sv
module rs_slot_track #(
  parameter int RF_CYC = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic real_i,
  output logic idle_o,
  output logic real_busy_o
);
  localparam int ACT_W = $clog2(RF_CYC + 1);

  logic [ACT_W-1:0] act_q;
  logic             real_q;

  assign idle_o      = (act_q == '0);
  assign real_busy_o = real_q && !idle_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= '0;
      real_q <= 1'b0;
    end else if (start_i) begin
      act_q  <= ACT_W'(RF_CYC - 1);
      real_q <= real_i;
    end else if (!idle_o) begin
      act_q <= act_q - ACT_W'(1);
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int CNT_W     = 8,
  parameter int RF_CYC    = 4,
  parameter int NUM_DUMMY = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             refresh_en_i,
  input  logic [CNT_W-1:0] interval_i,
  input  logic             mem_busy_i,
  input  logic             dma_req_i,
  output logic             start_o,
  output logic             dummy_o,
  output logic             pend_o,
  output logic             ext_hold_o
);
  import rs_pkg::*;

  logic     due;
  logic     dum_active;
  logic     slot_idle;
  logic     real_busy;
  logic     pend_q;
  logic     start_q;
  logic     dummy_q;
  rf_kind_e kind_c;

  rs_due_timer #(.CNT_W(CNT_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .en_i      (refresh_en_i),
    .interval_i(interval_i),
    .due_o     (due)
  );

  rs_dummy_seq #(.NUM_DUMMY(NUM_DUMMY)) u_dummy (
    .clk     (clk),
    .rst     (rst),
    .take_i  (kind_c == KIND_DUMMY),
    .active_o(dum_active)
  );

  rs_slot_track #(.RF_CYC(RF_CYC)) u_slot (
    .clk        (clk),
    .rst        (rst),
    .start_i    (kind_c != KIND_NONE),
    .real_i     (kind_c == KIND_REAL),
    .idle_o     (slot_idle),
    .real_busy_o(real_busy)
  );

  // dummies own the slot first; a real refresh needs a quiet bus
  always_comb begin
    kind_c = KIND_NONE;
    if (slot_idle) begin
      if (dum_active) begin
        kind_c = KIND_DUMMY;
      end else if (pend_q && refresh_en_i && !mem_busy_i && !dma_req_i) begin
        kind_c = KIND_REAL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= 1'b0;
      start_q <= 1'b0;
      dummy_q <= 1'b0;
    end else begin
      start_q <= (kind_c != KIND_NONE);
      dummy_q <= (kind_c == KIND_DUMMY);
      // a due arriving while already pending merges into the same request
      pend_q  <= refresh_en_i && ((pend_q && kind_c != KIND_REAL) || due);
    end
  end

  assign start_o    = start_q;
  assign dummy_o    = dummy_q;
  assign pend_o     = pend_q;
  assign ext_hold_o = pend_q || real_busy;
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk (
  input logic clk,
  input logic rst,
  input logic refresh_en_i,
  input logic mem_busy_i,
  input logic dma_req_i,
  input logic start_o,
  input logic dummy_o,
  input logic pend_o,
  input logic ext_hold_o
);
  // R4: a real start is preceded by a pending cycle
  p_start_after_pend_r4: assert property (@(posedge clk) disable iff (rst)
    (start_o && !dummy_o) |-> $past(pend_o));

  // R4: pending only drops through a real start or a disable
  p_pend_holds_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(pend_o) |-> ((start_o && !dummy_o) || !$past(refresh_en_i)));

  // R5: a real start never overlaps a busy memory cycle or DMA
  p_start_quiet_bus_r5: assert property (@(posedge clk) disable iff (rst)
    (start_o && !dummy_o) |-> (!$past(mem_busy_i) && !$past(dma_req_i)));

  // R8: disabled means nothing pending afterwards
  p_disabled_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(refresh_en_i) |-> !pend_o);

  // R2: the dummy qualifier only accompanies a start
  p_dummy_with_start_r2: assert property (@(posedge clk) disable iff (rst)
    dummy_o |-> start_o);

  // R9: external cycles are held while pending
  p_hold_covers_pend_r9: assert property (@(posedge clk) disable iff (rst)
    pend_o |-> ext_hold_o);

  // R10: pending is always driven
  p_pend_known_r10: assert property (@(posedge clk) disable iff (rst)
    !$isunknown(pend_o));
endmodule

bind refresh_sched refresh_sched_chk chk_i (
  .clk         (clk),
  .rst         (rst),
  .refresh_en_i(refresh_en_i),
  .mem_busy_i  (mem_busy_i),
  .dma_req_i   (dma_req_i),
  .start_o     (start_o),
  .dummy_o     (dummy_o),
  .pend_o      (pend_o),
  .ext_hold_o  (ext_hold_o)
);

// File: tb/refresh_sched_tb_top.sv
module refresh_sched_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 8;
  localparam int RF_CYC     = 4;
  localparam int NUM_DUMMY  = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             en = 1'b0;
  logic [CNT_W-1:0] iv = '0;
  logic             busy = 1'b0;
  logic             dma = 1'b0;
  logic             start_o, dummy_o, pend_o, ext_hold_o;

  int checks = 0;
  int fails  = 0;
  int dummies_seen = 0;
  int reals_seen = 0;

  // reference state
  int m_tmr, m_act, m_dleft;
  bit m_pend, m_real, e_start, e_dummy;

  refresh_sched #(.CNT_W(CNT_W), .RF_CYC(RF_CYC), .NUM_DUMMY(NUM_DUMMY)) dut_i (
    .clk(clk), .rst(rst), .refresh_en_i(en), .interval_i(iv),
    .mem_busy_i(busy), .dma_req_i(dma),
    .start_o(start_o), .dummy_o(dummy_o), .pend_o(pend_o), .ext_hold_o(ext_hold_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual=%b expected=%b", tag, $time, act, exp);
    end
  endtask

  function automatic bit exp_hold();
    return m_pend || (m_act != 0 && m_real);
  endfunction

  function automatic void model_reset();
    m_tmr = 0; m_act = 0; m_dleft = NUM_DUMMY;
    m_pend = 0; m_real = 0; e_start = 0; e_dummy = 0;
  endfunction

  // advance the model by one rising edge with the inputs now applied
  function automatic void model_step(bit f_en, int f_iv, bit f_busy, bit f_dma);
    bit idle, sd, sr, due;
    idle = (m_act == 0);
    sd   = idle && (m_dleft != 0);
    sr   = !sd && idle && m_pend && f_en && !f_busy && !f_dma;
    due  = f_en && (m_tmr <= 1);
    if (!f_en || m_tmr <= 1) m_tmr = f_iv; else m_tmr = m_tmr - 1;
    m_pend = f_en && ((m_pend && !sr) || due);
    if (sd || sr) begin
      m_act = RF_CYC - 1; m_real = sr;
    end else if (m_act != 0) begin
      m_act = m_act - 1;
    end
    if (sd) m_dleft = m_dleft - 1;
    e_start = sd || sr;
    e_dummy = sd;
  endfunction

  // at a falling edge: compare, then apply new inputs and step the model
  task automatic cycle(input bit f_en, input int f_iv, input bit f_busy, input bit f_dma);
    @(negedge clk);
    check(start_o,    e_start,  "R5 start_o");
    check(dummy_o,    e_dummy,  "R2 dummy_o");
    check(pend_o,     m_pend,   "R4 pend_o");
    check(ext_hold_o, exp_hold(), "R9 ext_hold_o");
    check(^pend_o === 1'bx, 1'b0, "R10 pend_o known");
    if (start_o && dummy_o) dummies_seen++;
    if (start_o && !dummy_o) reals_seen++;
    en = f_en; iv = CNT_W'(f_iv); busy = f_busy; dma = f_dma;
    model_step(f_en, f_iv, f_busy, f_dma);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    bit r_dma;
    void'($urandom(32'd5150));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(start_o, 1'b0, "R1 start_o in reset");
    check(dummy_o, 1'b0, "R1 dummy_o in reset");
    check(pend_o, 1'b0, "R1 pend_o in reset");
    check(ext_hold_o, 1'b0, "R1 ext_hold_o in reset");
    model_reset();
    rst = 1'b0; en = 1'b1; iv = CNT_W'(5); busy = 1'b0; dma = 1'b1;
    model_step(1'b1, 5, 1'b0, 1'b1);

    // directed: DMA held across the whole dummy burst (R2, R5)
    for (int i = 0; i < 60; i++) cycle(1'b1, 5, 1'b0, i < 45);
    checks++;
    if (dummies_seen != NUM_DUMMY) begin
      fails++;
      $display("FAIL R2 dummy count: actual=%0d expected=%0d", dummies_seen, NUM_DUMMY);
    end

    // random mix of enable glitches, busy cycles and DMA bursts (R3 R4 R5 R6)
    r_dma = 1'b0;
    for (int i = 0; i < 1500; i++) begin
      if (($urandom % 8) == 0) r_dma = ~r_dma;
      cycle(($urandom % 10) != 0, 1 + ($urandom % 12), ($urandom % 3) == 0, r_dma);
    end

    // R8: disabled stretch produces no real start
    cycle(1'b0, 4, 1'b0, 1'b0);
    reals_seen = 0;
    for (int i = 0; i < 200; i++) cycle(1'b0, 1 + ($urandom % 12), ($urandom % 2) == 0, ($urandom % 2) == 0);
    checks++;
    if (reals_seen != 0) begin
      fails++;
      $display("FAIL R8 starts while disabled: actual=%0d expected=0", reals_seen);
    end

    // R7: interval 1 makes dues pile up while pending
    r_dma = 1'b0;
    for (int i = 0; i < 300; i++) begin
      if (($urandom % 6) == 0) r_dma = ~r_dma;
      cycle(1'b1, 1, ($urandom % 4) == 0, r_dma);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule